// File: doc/BRIEF.md
# DC Fault Protection and Restoration Sequencer

This block is the protection controller for one converter terminal of a multi-terminal DC grid. Each valid sample of terminal DC current and bus voltage is compared with trip levels derived from the terminal's rated power and rated bus voltage. When either level is crossed, the converter is blocked. The controller then waits for the line fault current to settle inside a small band around zero, opens the line disconnectors, and moves the terminal into its restoration role.

One terminal is marked as the grid re-energizer. That terminal runs a timed submodule discharge. It then closes an auxiliary pre-charge path and deblocks to charge the grid. When the bus reaches ninety percent of rated voltage, it swaps the auxiliary path for the main switch and pulses a release to its peers. Every other terminal stays blocked after isolation until the peer release arrives. The switch controls and the state code are decoded from registered state.

Top module: `dcfp_sequencer`

## Requirements
- R1: A fault is detected on a valid sample when 5·|i_dc|·rated_v > 6·rated_p (overcurrent) or 20·v_dc < 17·rated_v (undervoltage). Either condition alone is enough. In the running state both conditions are checked. In the pre-charge state only overcurrent counts.
- R2: A valid faulting sample in the running state makes gate_block high and state_code 1 after the next rising clock edge. Samples with smp_vld low have no effect.
- R3: In the blocked state (code 1), the move to isolation (code 2) happens on the valid sample that completes zero_hold consecutive valid samples with |i_line| ≤ zero_band. The band is inclusive. A valid sample outside the band restarts the count. Invalid samples neither count nor restart. A zero_hold of 0 behaves as 1.
- R4: disc_open rises on the edge that enters isolation. It then stays high until reset, including after restoration.
- R5: Isolation lasts one cycle. With is_leader high, the controller then spends exactly DISCH_CYC cycles in discharge (code 3, dsch_on high), with the converter blocked. With is_leader low, it waits blocked in code 5, with dsch_on and aux_close low, until peer_release is high. It then returns to running. peer_release has no effect in any other state.
- R6: In pre-charge (code 4), aux_close is high, and gate_block and main_close are low. A valid sample with 10·v_dc ≥ 9·rated_v and no overcurrent returns the controller to running (code 0) on the next edge. On that edge main_close rises and aux_close falls, and release_all is high for exactly one cycle.
- R7: A valid overcurrent sample during pre-charge returns the controller to the blocked state (code 1), with aux_close low and gate_block high.
- R8: main_close and aux_close are never high in the same cycle.
- R9: While rst_n is low and after its release, the state is running (code 0): main_close high, gate_block, aux_close, dsch_on, disc_open and release_all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample inputs are valid this cycle |
| i_dc | input | IW | Terminal DC current, signed |
| v_dc | input | VW | DC bus voltage, unsigned |
| i_line | input | IW | Protected line current, signed |
| rated_v | input | VW | Rated bus voltage, same scale as v_dc |
| rated_p | input | IW+VW | Rated power, in current LSB times voltage LSB |
| zero_band | input | IW | Half-width of the zero-current band |
| zero_hold | input | CW | Consecutive in-band samples needed |
| is_leader | input | 1 | This terminal re-energizes the grid |
| peer_release | input | 1 | Deblock-all release from the leader terminal |
| gate_block | output | 1 | Block all converter switches |
| disc_open | output | 1 | Line disconnectors open |
| dsch_on | output | 1 | Submodule discharge switch on |
| aux_close | output | 1 | Auxiliary pre-charge switch closed |
| main_close | output | 1 | Main AC switch closed |
| release_all | output | 1 | One-cycle deblock release to other terminals |
| state_code | output | 3 | 0 run, 1 blocked, 2 isolate, 3 discharge, 4 pre-charge, 5 wait for peer |

## Verification
The bench uses 12-bit current and voltage samples, an 8-bit hold counter and DISCH_CYC of 20. With these values, a full fault, isolation, discharge and pre-charge round trip fits in a few dozen cycles. With rated values of 1000 and 100000, the trip levels fall on round numbers: the overcurrent level is a magnitude of 120, the undervoltage level is 850 and the restore target is 900. Inputs one step either side of each level can therefore be driven directly. Random samples around those levels exercise the OR of both detectors in the running state.

// File: rtl/dcfp_pkg.sv
package dcfp_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_BLOCK = 3'd1,
    ST_ISO   = 3'd2,
    ST_DISCH = 3'd3,
    ST_PRE   = 3'd4,
    ST_WAIT  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dcfp_detect.sv
// Threshold comparisons done by cross-multiplication, no divider.
module dcfp_detect #(
  parameter int IW = 16,
  parameter int VW = 16
) (
  input  logic signed [IW-1:0]    i_dc,
  input  logic        [VW-1:0]    v_dc,
  input  logic        [VW-1:0]    rated_v,
  input  logic        [IW+VW-1:0] rated_p,
  output logic                    over_i,
  output logic                    under_v,
  output logic                    at_target
);
  localparam int MW = IW + VW + 3;
  localparam int XW = VW + 5;

  logic [IW-1:0] mag;
  logic [MW-1:0] i_lhs, i_rhs;
  logic [XW-1:0] v20, r17, v10, r9;

  always_comb begin
    mag   = i_dc[IW-1] ? IW'(-i_dc) : IW'(i_dc);
    i_lhs = MW'(mag) * MW'(rated_v) * MW'(5);
    i_rhs = MW'(rated_p) * MW'(6);
    v20   = XW'(v_dc) * XW'(20);
    r17   = XW'(rated_v) * XW'(17);
    v10   = XW'(v_dc) * XW'(10);
    r9    = XW'(rated_v) * XW'(9);
    over_i    = i_lhs > i_rhs;
    under_v   = v20 < r17;
    at_target = v10 >= r9;
  end
endmodule

// File: rtl/dcfp_zero_qual.sv
// Counts consecutive valid in-band line current samples.
module dcfp_zero_qual #(
  parameter int IW = 16,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 smp_vld,
  input  logic signed [IW-1:0] i_line,
  input  logic        [IW-1:0] band,
  input  logic        [CW-1:0] hold_n,
  output logic                 done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] mag;
  logic          in_band;
  logic [CW:0]   need, reach;

  always_comb begin
    mag     = i_line[IW-1] ? IW'(-i_line) : IW'(i_line);
    in_band = mag <= band;
    need    = (hold_n == '0) ? (CW+1)'(1) : {1'b0, hold_n};
    reach   = {1'b0, cnt_q} + (CW+1)'(1);
    done    = en && smp_vld && in_band && (reach >= need);
    if (!en)
      cnt_d = '0;
    else if (smp_vld)
      cnt_d = !in_band ? '0 : (&cnt_q ? cnt_q : cnt_q + CW'(1));
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dcfp_timer.sv
// Down counter: load sets CNT-1, dec counts to zero and holds there.
module dcfp_timer #(
  parameter int CNT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);
  localparam int TW = (CNT < 2) ? 1 : $clog2(CNT + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    zero = (cnt_q == '0);
    if (load)
      cnt_d = TW'(CNT - 1);
    else if (dec && !zero)
      cnt_d = cnt_q - TW'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dcfp_sequencer.sv
module dcfp_sequencer
  import dcfp_pkg::*;
#(
  parameter int IW        = 16,
  parameter int VW        = 16,
  parameter int CW        = 8,
  parameter int DISCH_CYC = 12_500_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [IW-1:0]    i_dc,
  input  logic        [VW-1:0]    v_dc,
  input  logic signed [IW-1:0]    i_line,
  input  logic        [VW-1:0]    rated_v,
  input  logic        [IW+VW-1:0] rated_p,
  input  logic        [IW-1:0]    zero_band,
  input  logic        [CW-1:0]    zero_hold,
  input  logic                    is_leader,
  input  logic                    peer_release,
  output logic                    gate_block,
  output logic                    disc_open,
  output logic                    dsch_on,
  output logic                    aux_close,
  output logic                    main_close,
  output logic                    release_all,
  output logic [2:0]              state_code
);
  seq_state_e state_q, state_d;
  logic disc_q, disc_d, rel_q, rel_d;
  logic over_i, under_v, at_target, zq_done, tmr_zero;

  dcfp_detect #(.IW(IW), .VW(VW)) u_detect (
    .i_dc(i_dc), .v_dc(v_dc), .rated_v(rated_v), .rated_p(rated_p),
    .over_i(over_i), .under_v(under_v), .at_target(at_target)
  );

  dcfp_zero_qual #(.IW(IW), .CW(CW)) u_zq (
    .clk(clk), .rst_n(rst_n), .en(state_q == ST_BLOCK), .smp_vld(smp_vld),
    .i_line(i_line), .band(zero_band), .hold_n(zero_hold), .done(zq_done)
  );

  dcfp_timer #(.CNT(DISCH_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(state_q == ST_ISO),
    .dec(state_q == ST_DISCH), .zero(tmr_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (smp_vld && (over_i || under_v)) state_d = ST_BLOCK;
      ST_BLOCK: if (zq_done) state_d = ST_ISO;
      ST_ISO:   state_d = is_leader ? ST_DISCH : ST_WAIT;
      ST_DISCH: if (tmr_zero) state_d = ST_PRE;
      ST_PRE: begin
        if (smp_vld && over_i)         state_d = ST_BLOCK;
        else if (smp_vld && at_target) state_d = ST_RUN;
      end
      ST_WAIT:  if (peer_release) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
    disc_d = disc_q | (state_d == ST_ISO);
    rel_d  = (state_q == ST_PRE) && (state_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      disc_q  <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      disc_q  <= disc_d;
      rel_q   <= rel_d;
    end
  end

  always_comb begin
    gate_block  = (state_q == ST_BLOCK) || (state_q == ST_ISO) ||
                  (state_q == ST_DISCH) || (state_q == ST_WAIT);
    dsch_on     = (state_q == ST_DISCH);
    aux_close   = (state_q == ST_PRE);
    main_close  = (state_q == ST_RUN);
    disc_open   = disc_q;
    release_all = rel_q;
    state_code  = state_q;
  end
endmodule

// File: rtl/dcfp_sequencer_chk.sv
module dcfp_sequencer_chk #(
  parameter int IW = 16,
  parameter int VW = 16,
  parameter int CW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_vld,
  input logic signed [IW-1:0]    i_line,
  input logic        [VW-1:0]    v_dc,
  input logic        [VW-1:0]    rated_v,
  input logic        [IW-1:0]    zero_band,
  input logic                    is_leader,
  input logic                    gate_block,
  input logic                    disc_open,
  input logic                    dsch_on,
  input logic                    aux_close,
  input logic                    main_close,
  input logic                    release_all,
  input logic [2:0]              state_code
);
  logic [IW-1:0]  line_mag;
  logic [VW+4:0]  v20, r17;
  logic           near_zero, low_bus;

  always_comb begin
    line_mag  = i_line[IW-1] ? IW'(-i_line) : IW'(i_line);
    near_zero = smp_vld && (line_mag <= zero_band);
    v20       = (VW+5)'(v_dc) * (VW+5)'(20);
    r17       = (VW+5)'(rated_v) * (VW+5)'(17);
    low_bus   = v20 < r17;
  end

  AST_UV_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0 && smp_vld && low_bus) |=> gate_block); // R1
  AST_DISC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disc_open) |-> $past(near_zero)); // R3
  AST_DISC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    disc_open |=> disc_open); // R4
  AST_FOLLOWER_NO_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && !is_leader) |=> !dsch_on); // R5
  AST_AUX_AFTER_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_close) |-> $past(dsch_on)); // R6
  AST_RELEASE_ON_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    release_all |-> (main_close && !aux_close && !gate_block)); // R6
  AST_NO_DUAL_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_close && aux_close)); // R8
endmodule

bind dcfp_sequencer dcfp_sequencer_chk #(.IW(IW), .VW(VW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .i_line(i_line), .v_dc(v_dc),
  .rated_v(rated_v), .zero_band(zero_band), .is_leader(is_leader),
  .gate_block(gate_block), .disc_open(disc_open), .dsch_on(dsch_on),
  .aux_close(aux_close), .main_close(main_close), .release_all(release_all),
  .state_code(state_code)
);

// File: tb/dcfp_sequencer_bench.sv
`timescale 1ns/1ps
module dcfp_sequencer_bench;
  localparam int IW = 12, VW = 12, CW = 8, DC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_vld = 1'b0, is_leader = 1'b1, peer_release = 1'b0;
  logic signed [IW-1:0] i_dc = '0, i_line = '0;
  logic [VW-1:0] v_dc = 12'd1000, rated_v = 12'd1000;
  logic [IW+VW-1:0] rated_p = 24'd100000;
  logic [IW-1:0] zero_band = 12'd5;
  logic [CW-1:0] zero_hold = 8'd3;
  logic gate_block, disc_open, dsch_on, aux_close, main_close, release_all;
  logic [2:0] state_code;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dcfp_sequencer #(.IW(IW), .VW(VW), .CW(CW), .DISCH_CYC(DC)) u_dcfp_sequencer (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .i_dc(i_dc), .v_dc(v_dc),
    .i_line(i_line), .rated_v(rated_v), .rated_p(rated_p), .zero_band(zero_band),
    .zero_hold(zero_hold), .is_leader(is_leader), .peer_release(peer_release),
    .gate_block(gate_block), .disc_open(disc_open), .dsch_on(dsch_on),
    .aux_close(aux_close), .main_close(main_close), .release_all(release_all),
    .state_code(state_code)
  );

  function automatic bit exp_fault(int i, int v);
    int m;
    m = (i < 0) ? -i : i;
    return (5 * m * 1000 > 6 * 100000) || (20 * v < 17 * 1000);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic smp(int i, int v, int il);
    smp_vld = 1'b1; i_dc = IW'(i); v_dc = VW'(v); i_line = IW'(il);
    tick();
    smp_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
  endtask

  task automatic run_discharge();
    int n = 0;
    while (dsch_on && n < 1000) begin n++; tick(); end
    check("R5 discharge length", n, DC);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) tick();
    check("R9 reset state", state_code, 0);
    check("R9 reset main", main_close, 1);
    rst_n = 1'b1; tick();
    check("R9 block low", gate_block, 0);
    check("R9 aux/disc/dsch/rel low", {aux_close, disc_open, dsch_on, release_all}, 0);

    // leader round trip
    smp(200, 1000, 100);
    check("R2 overcurrent blocks", state_code, 1);
    check("R2 gate_block", gate_block, 1);
    check("R8 main open when blocked", main_close, 0);
    smp(0, 1000, 3); smp(0, 1000, 4); smp(0, 1000, 10);
    check("R3 out-of-band restarts", state_code, 1);
    smp(0, 1000, 2); smp(0, 1000, -5);
    check("R4 disc still closed", disc_open, 0);
    tick();
    check("R3 idle sample keeps block", state_code, 1);
    smp(0, 1000, 0);
    check("R3 isolation after hold", state_code, 2);
    check("R4 disconnector opens", disc_open, 1);
    tick();
    check("R5 leader discharge", state_code, 3);
    run_discharge();
    check("R6 pre-charge state", state_code, 4);
    check("R6 aux closed", aux_close, 1);
    check("R6 deblocked, main open", {gate_block, main_close}, 0);
    smp(0, 500, 0);
    check("R1 undervoltage ignored in pre-charge", state_code, 4);
    smp(0, 899, 0);
    check("R6 below target stays", state_code, 4);
    smp(130, 950, 0);
    check("R7 overcurrent in pre-charge", state_code, 1);
    check("R7 aux opened", aux_close, 0);
    smp(0, 1000, 1); smp(0, 1000, 1); smp(0, 1000, 1);
    check("R3 requalify", state_code, 2);
    tick();
    run_discharge();
    smp(0, 900, 0);
    check("R6 restored run", state_code, 0);
    check("R6 main closed aux open", {main_close, aux_close}, 2'b10);
    check("R6 release pulse", release_all, 1);
    tick();
    check("R6 release one cycle", release_all, 0);
    check("R4 disconnector stays open", disc_open, 1);
    i_dc = 12'sd500; tick();
    check("R2 invalid sample ignored", state_code, 0);
    i_dc = '0; peer_release = 1'b1; tick(); peer_release = 1'b0;
    check("R5 peer release ignored in run", state_code, 0);

    // follower
    is_leader = 1'b0; do_reset();
    smp(120, 1000, 0);
    check("R1 current at level no trip", state_code, 0);
    smp(0, 850, 0);
    check("R1 voltage at level no trip", state_code, 0);
    smp(0, 849, 0);
    check("R1 undervoltage trips", state_code, 1);
    zero_hold = 8'd0;
    smp(0, 849, -1);
    check("R3 zero hold acts as one", state_code, 2);
    tick();
    check("R5 follower waits", state_code, 5);
    check("R5 follower blocked no discharge", {gate_block, dsch_on, aux_close}, 3'b100);
    repeat (5) tick();
    check("R5 still waiting", state_code, 5);
    peer_release = 1'b1; tick(); peer_release = 1'b0;
    check("R5 released to run", state_code, 0);
    check("R5 deblocked main closed", {gate_block, main_close}, 2'b01);

    // random detection in run state
    zero_hold = 8'd3; do_reset();
    for (int k = 0; k < 60; k++) begin
      int ri, rv;
      bit f;
      ri = int'($urandom_range(400)) - 200;
      rv = int'($urandom_range(300)) + 800;
      f  = exp_fault(ri, rv);
      smp(ri, rv, 0);
      check("R1 random detection", gate_block, int'(f));
      if (f) do_reset();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule